// File: doc/BRIEF.md
# Byte-Serial SPI Controller with Select-Fault Recovery

This block is a byte-wide SPI port that runs either as bus master or as slave, the role being picked by a control bit. As master it generates a mode-0 serial clock from a fixed divider of the system clock and exchanges one byte per data-register write. As slave it follows an external serial clock, but only while its select line is low. A rising select discards any byte that is partly shifted. The select line of a master can serve as a plain output, or it can be watched as an input. When it is watched, another device pulling it low makes the block drop back to slave and release its clock and data-out drivers.

Software reaches the block through a small register port. The port holds a control register, a status register with a completion flag, and a data register. The four serial signals can be steered to one of two pad sets. Each pad has its own input, output value and output-enable. An interrupt line reports the flag when both the local and the global enable are on.

Top module: `spi_ctrl`

## Requirements
- R1: After reset the control, status and data registers read 0, every pad output-enable is 0 and `irq` is 0.
- R2: Register map: address 0 control, 1 status, 2 data. Control bits are 0 enable, 1 master, 2 interrupt enable, 3 select-is-output, 4 select output level, 5 slave data-out enable and 6 alternate pad set. A data write to an idle enabled master sends 8 bits MSB first in mode 0: the clock idles low, each half period lasts `HALF_DIV` clock cycles, data-in is sampled on the rising edge and the next data-out bit follows the falling edge. The received byte is then readable at address 2.
- R3: Status bit 7 is set when a byte completes or a mode fault occurs. A data-register access clears it only if a status read that saw it set came first. A data access on its own leaves it set. `irq` equals that flag ANDed with control bit 2 and `glb_ie`.
- R4: As an enabled slave with select low, the block samples its data input on rising serial-clock edges and drives its data output MSB first from the last data write. It drives data-out only while select is low and control bit 5 is 1.
- R5: As a slave with select high, every output-enable is 0, and serial clock and data activity change neither the flag nor the data register.
- R6: A rising slave select clears the bit counter and reloads the last written transmit byte. A partial byte sets no flag, and the next full byte is received and transmitted correctly.
- R7: In master mode with control bit 3 set, the select pad is driven with control bit 4, and a low select input has no effect on the master.
- R8: In master mode with control bit 3 clear, a low select input causes a mode fault. The master bit clears, the clock and data-out enables drop, any transfer stops and the flag is set.
- R9: After a mode fault the master bit stays 0 until software writes it as 1.
- R10: Control bit 6 = 0 routes all four signals to pad set 0 and 1 routes them to pad set 1. The unselected set has every output-enable at 0, and its inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational on address) |
| glb_ie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| pad_sck_i | input | 2 | Serial clock in, per pad set |
| pad_sck_o | output | 2 | Serial clock out, per pad set |
| pad_sck_oe | output | 2 | Serial clock enable, per pad set |
| pad_mosi_i | input | 2 | Master-out line in, per pad set |
| pad_mosi_o | output | 2 | Master-out line out, per pad set |
| pad_mosi_oe | output | 2 | Master-out enable, per pad set |
| pad_miso_i | input | 2 | Master-in line in, per pad set |
| pad_miso_o | output | 2 | Master-in line out, per pad set |
| pad_miso_oe | output | 2 | Master-in enable, per pad set |
| pad_ss_i | input | 2 | Select in, per pad set |
| pad_ss_o | output | 2 | Select out, per pad set |
| pad_ss_oe | output | 2 | Select enable, per pad set |

## Verification
Master exchanges use bytes with alternating, all-zero, all-one and edge-only bit patterns, so a reversed bit order, a bit lost at either end, or a slip of one position each give a distinct wrong byte. Every exchange is tried on both pad sets, with inverted data on the idle set's input, which separates correct routing from crossed routing. Slave bytes are run whole, cut off after four bits, and with select held high. These three cases tell a counter that truly restarts from one that keeps stale bits. Mode faults are provoked in the middle of a transfer and compared with the same low select when the select pad is an output or sits on the idle set.

// File: rtl/spi_ctrl_pkg.sv
`timescale 1ns/1ps
// Shared constants and types of the SPI controller.
// Assumes a byte-wide data path and exactly two pad sets.
package spi_ctrl_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam int CTRL_W = 7;
    localparam int NSETS  = 2;
    localparam int SEL_W  = $clog2(NSETS);

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    // Control register, bit 6 down to bit 0.
    typedef struct packed {
        logic alt;       // 6: alternate pad set
        logic miso_en;   // 5: slave data-out enable
        logic sel_lvl;   // 4: select output level
        logic sel_out;   // 3: select is an output in master mode
        logic irq_en;    // 2: interrupt enable
        logic master;    // 1: master role
        logic en;        // 0: block enable
    } ctrl_t;

    // One bit per serial signal.
    typedef struct packed {
        logic sck;
        logic mosi;
        logic miso;
        logic ss;
    } pins_t;
endpackage

// File: rtl/spi_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a vector of asynchronous pad inputs.
// Assumes each bit is independent; RST_VAL gives the idle level.
module spi_sync #(
    parameter int              W       = 4,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Two register stages per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/spi_pinmux.sv
`timescale 1ns/1ps
// Steers the core's four serial signals to one of NSETS pad sets.
// Unselected sets get zero outputs and enables; their inputs are not used.
module spi_pinmux
    import spi_ctrl_pkg::*;
#(
    parameter int SETS = NSETS,
    localparam int SW  = $clog2(SETS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SW-1:0]   sel,
    input  pins_t           core_o,
    input  pins_t           core_oe,
    output pins_t           core_i,
    input  logic [SETS-1:0] pad_sck_i,
    output logic [SETS-1:0] pad_sck_o,
    output logic [SETS-1:0] pad_sck_oe,
    input  logic [SETS-1:0] pad_mosi_i,
    output logic [SETS-1:0] pad_mosi_o,
    output logic [SETS-1:0] pad_mosi_oe,
    input  logic [SETS-1:0] pad_miso_i,
    output logic [SETS-1:0] pad_miso_o,
    output logic [SETS-1:0] pad_miso_oe,
    input  logic [SETS-1:0] pad_ss_i,
    output logic [SETS-1:0] pad_ss_o,
    output logic [SETS-1:0] pad_ss_oe
);
    logic [SETS-1:0] hit;
    logic [SETS-1:0] drives;

    // One output branch per pad set.
    for (genvar k = 0; k < SETS; k++) begin : g_set
        assign hit[k]         = (sel == SW'(k));
        assign pad_sck_o[k]   = hit[k] & core_o.sck;
        assign pad_sck_oe[k]  = hit[k] & core_oe.sck;
        assign pad_mosi_o[k]  = hit[k] & core_o.mosi;
        assign pad_mosi_oe[k] = hit[k] & core_oe.mosi;
        assign pad_miso_o[k]  = hit[k] & core_o.miso;
        assign pad_miso_oe[k] = hit[k] & core_oe.miso;
        assign pad_ss_o[k]    = hit[k] & core_o.ss;
        assign pad_ss_oe[k]   = hit[k] & core_oe.ss;
        assign drives[k]      = pad_sck_oe[k] | pad_mosi_oe[k] | pad_miso_oe[k] | pad_ss_oe[k];
    end

    // Input selection from the chosen set.
    assign core_i.sck  = pad_sck_i[sel];
    assign core_i.mosi = pad_mosi_i[sel];
    assign core_i.miso = pad_miso_i[sel];
    assign core_i.ss   = pad_ss_i[sel];

    AST_ONE_SET_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(drives)); // R10
endmodule

// File: rtl/spi_engine.sv
`timescale 1ns/1ps
// Shift engine: mode-0 master clock generator, shared shift register and
// slave edge follower. Assumes pin_in is already synchronized and that an
// external serial clock half period spans several system clocks.
module spi_engine
    import spi_ctrl_pkg::*;
#(
    parameter int HALF_DIV = 4,
    localparam int DIV_W   = $clog2(HALF_DIV + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              master,
    input  logic              sel_out,
    input  logic              sel_lvl,
    input  logic              miso_en,
    input  pins_t             pin_in,
    input  logic              wr_data,
    input  logic [BYTE_W-1:0] wdata,
    output logic              fault,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte,
    output pins_t             pin_o,
    output pins_t             pin_oe
);
    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] tx_q;
    logic [CNT_W-1:0]  bit_q;
    logic [DIV_W-1:0]  div_q;
    logic              cap_q;
    logic              run_q;
    logic              sckm_q;
    logic              scks_d;
    logic              done_q;
    logic              s_rise;
    logic              s_fall;
    logic              last_bit;
    logic              half_end;

    assign s_rise   = pin_in.sck & ~scks_d;
    assign s_fall   = ~pin_in.sck & scks_d;
    assign last_bit = (bit_q == CNT_W'(BYTE_W - 1));
    assign half_end = (div_q == DIV_W'(HALF_DIV - 1));
    assign fault    = en & master & ~sel_out & ~pin_in.ss;

    // History of the synchronized serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) scks_d <= 1'b0;
        else        scks_d <= pin_in.sck;
    end

    // Master sequencing, slave shifting and select-driven flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            tx_q   <= '0;
            bit_q  <= '0;
            div_q  <= '0;
            cap_q  <= 1'b0;
            run_q  <= 1'b0;
            sckm_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!en) begin
                run_q  <= 1'b0;
                sckm_q <= 1'b0;
                div_q  <= '0;
                bit_q  <= '0;
                if (wr_data) begin
                    sh_q <= wdata;
                    tx_q <= wdata;
                end
            end else if (master) begin
                if (fault) begin
                    run_q  <= 1'b0;
                    sckm_q <= 1'b0;
                    div_q  <= '0;
                    bit_q  <= '0;
                end else if (!run_q) begin
                    if (wr_data) begin
                        sh_q  <= wdata;
                        tx_q  <= wdata;
                        run_q <= 1'b1;
                        div_q <= '0;
                        bit_q <= '0;
                    end
                end else if (half_end) begin
                    div_q  <= '0;
                    sckm_q <= ~sckm_q;
                    if (!sckm_q) begin
                        cap_q <= pin_in.miso;
                    end else begin
                        sh_q  <= {sh_q[BYTE_W-2:0], cap_q};
                        bit_q <= bit_q + 1'b1;
                        if (last_bit) begin
                            run_q  <= 1'b0;
                            done_q <= 1'b1;
                        end
                    end
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end else begin
                run_q  <= 1'b0;
                sckm_q <= 1'b0;
                div_q  <= '0;
                if (pin_in.ss) begin
                    bit_q <= '0;
                    if (wr_data) begin
                        sh_q <= wdata;
                        tx_q <= wdata;
                    end else begin
                        sh_q <= tx_q;
                    end
                end else begin
                    if (s_rise) cap_q <= pin_in.mosi;
                    if (s_fall) begin
                        sh_q  <= {sh_q[BYTE_W-2:0], cap_q};
                        bit_q <= bit_q + 1'b1;
                        if (last_bit) done_q <= 1'b1;
                    end else if (wr_data && bit_q == '0) begin
                        sh_q <= wdata;
                        tx_q <= wdata;
                    end
                end
            end
        end
    end

    assign done    = done_q;
    assign rx_byte = sh_q;

    // Pad values and enables for the current role.
    always_comb begin
        pin_o  = '0;
        pin_oe = '0;
        if (en && master) begin
            pin_o.sck   = sckm_q;
            pin_oe.sck  = 1'b1;
            pin_o.mosi  = sh_q[BYTE_W-1];
            pin_oe.mosi = 1'b1;
            pin_o.ss    = sel_lvl;
            pin_oe.ss   = sel_out;
        end else if (en) begin
            pin_o.miso  = sh_q[BYTE_W-1];
            pin_oe.miso = miso_en & ~pin_in.ss;
        end
    end

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !run_q |-> !sckm_q); // R2
    AST_DONE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n) done_q |-> (bit_q == '0)); // R2
    AST_SLAVE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n) (en && !master && pin_in.ss) |=> (bit_q == '0)); // R6
    AST_FAULT_HALTS: assert property (@(posedge clk) disable iff (!rst_n) fault |=> !run_q); // R8
endmodule

// File: rtl/spi_regs.sv
`timescale 1ns/1ps
// Register port: control, status flag with read-then-access clearing,
// received-data holding register and interrupt gating.
// Assumes single-cycle read and write strobes.
module spi_regs
    import spi_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              gie,
    output logic              irq,
    input  logic              done,
    input  logic              fault,
    input  logic [BYTE_W-1:0] rx_byte,
    output ctrl_t             ctrl,
    output logic              wr_data
);
    ctrl_t             ctrl_q;
    logic              flag_q;
    logic              armed_q;
    logic [BYTE_W-1:0] rx_q;
    logic              ctrl_wr;
    logic              stat_rd;
    logic              data_acc;

    assign ctrl_wr  = wr & (addr == A_CTRL);
    assign stat_rd  = rd & (addr == A_STAT);
    assign data_acc = (wr | rd) & (addr == A_DATA);
    assign wr_data  = wr & (addr == A_DATA);

    // Control register; a mode fault overrides the master bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= ctrl_t'(ctrl_wdata);
            if (fault)   ctrl_q.master <= 1'b0;
        end
    end

    // Completion flag: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                  flag_q <= 1'b0;
        else if (done || fault)      flag_q <= 1'b1;
        else if (data_acc && armed_q) flag_q <= 1'b0;
    end

    // Arming by a status read that observed the flag set.
    always_ff @(posedge clk) begin
        if (!rst_n)                armed_q <= 1'b0;
        else if (done || fault)    armed_q <= 1'b0;
        else if (data_acc)         armed_q <= 1'b0;
        else if (stat_rd && flag_q) armed_q <= 1'b1;
    end

    // Received byte capture.
    always_ff @(posedge clk) begin
        if (!rst_n)    rx_q <= '0;
        else if (done) rx_q <= rx_byte;
    end

    // Read multiplexer.
    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = {1'b0, ctrl_q};
            A_STAT:  rdata = {flag_q, {(BYTE_W-1){1'b0}}};
            A_DATA:  rdata = rx_q;
            default: rdata = '0;
        endcase
    end

    assign ctrl = ctrl_q;
    assign irq  = flag_q & ctrl_q.irq_en & gie;

    AST_FAULT_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rst_n) fault |=> !ctrl_q.master); // R8
    AST_FAULT_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n) fault |=> flag_q); // R8
    AST_MASTER_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (!ctrl_q.master && !ctrl_wr) |=> !ctrl_q.master); // R9
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (flag_q && !data_acc) |=> flag_q); // R3
endmodule

// File: rtl/spi_ctrl.sv
`timescale 1ns/1ps
// Top of the SPI controller: pad steering, input synchronization,
// shift engine and register port.
// Assumes pad inputs are asynchronous to clk.
module spi_ctrl
    import spi_ctrl_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              glb_ie,
    output logic              irq,
    input  logic [1:0]        pad_sck_i,
    output logic [1:0]        pad_sck_o,
    output logic [1:0]        pad_sck_oe,
    input  logic [1:0]        pad_mosi_i,
    output logic [1:0]        pad_mosi_o,
    output logic [1:0]        pad_mosi_oe,
    input  logic [1:0]        pad_miso_i,
    output logic [1:0]        pad_miso_o,
    output logic [1:0]        pad_miso_oe,
    input  logic [1:0]        pad_ss_i,
    output logic [1:0]        pad_ss_o,
    output logic [1:0]        pad_ss_oe
);
    ctrl_t             ctrl;
    pins_t             raw_in;
    pins_t             sync_in;
    pins_t             core_o;
    pins_t             core_oe;
    logic              wr_data;
    logic              fault;
    logic              done;
    logic [BYTE_W-1:0] rx_byte;

    spi_pinmux #(.SETS(NSETS)) i_pinmux (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (ctrl.alt),
        .core_o      (core_o),
        .core_oe     (core_oe),
        .core_i      (raw_in),
        .pad_sck_i   (pad_sck_i),
        .pad_sck_o   (pad_sck_o),
        .pad_sck_oe  (pad_sck_oe),
        .pad_mosi_i  (pad_mosi_i),
        .pad_mosi_o  (pad_mosi_o),
        .pad_mosi_oe (pad_mosi_oe),
        .pad_miso_i  (pad_miso_i),
        .pad_miso_o  (pad_miso_o),
        .pad_miso_oe (pad_miso_oe),
        .pad_ss_i    (pad_ss_i),
        .pad_ss_o    (pad_ss_o),
        .pad_ss_oe   (pad_ss_oe)
    );

    spi_sync #(.W(4), .RST_VAL(4'b0001)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_in)
    );

    spi_engine #(.HALF_DIV(HALF_DIV)) i_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl.en),
        .master  (ctrl.master),
        .sel_out (ctrl.sel_out),
        .sel_lvl (ctrl.sel_lvl),
        .miso_en (ctrl.miso_en),
        .pin_in  (sync_in),
        .wr_data (wr_data),
        .wdata   (reg_wdata),
        .fault   (fault),
        .done    (done),
        .rx_byte (rx_byte),
        .pin_o   (core_o),
        .pin_oe  (core_oe)
    );

    spi_regs i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (reg_addr),
        .wr         (reg_wr),
        .rd         (reg_rd),
        .ctrl_wdata (reg_wdata[CTRL_W-1:0]),
        .rdata      (reg_rdata),
        .gie        (glb_ie),
        .irq        (irq),
        .done       (done),
        .fault      (fault),
        .rx_byte    (rx_byte),
        .ctrl       (ctrl),
        .wr_data    (wr_data)
    );
endmodule

// File: tb/test_spi_ctrl.sv
`timescale 1ns/1ps
module test_spi_ctrl;
    localparam int HALF = 4;
    localparam logic [7:0] C_EN = 8'h01, C_MST = 8'h02, C_IE = 8'h04, C_SOUT = 8'h08,
                           C_SLVL = 8'h10, C_MEN = 8'h20, C_ALT = 8'h40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic reg_wr = 1'b0, reg_rd = 1'b0, glb_ie = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    wire  [7:0] reg_rdata;
    wire  irq;
    logic [1:0] sck_i = 2'b00, mosi_i = 2'b00, miso_i = 2'b00, ss_i = 2'b11;
    wire  [1:0] sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_o, ss_oe;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    spi_ctrl #(.HALF_DIV(HALF)) i_spi_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .glb_ie(glb_ie), .irq(irq),
        .pad_sck_i(sck_i), .pad_sck_o(sck_o), .pad_sck_oe(sck_oe),
        .pad_mosi_i(mosi_i), .pad_mosi_o(mosi_o), .pad_mosi_oe(mosi_oe),
        .pad_miso_i(miso_i), .pad_miso_o(miso_o), .pad_miso_oe(miso_oe),
        .pad_ss_i(ss_i), .pad_ss_o(ss_o), .pad_ss_oe(ss_oe)
    );

    // Watchdog: an expired run counts as one failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Master exchange on pad set s; bench plays the remote slave.
    task automatic master_xfer(input int s, input logic [7:0] tx, input logic [7:0] slv, input string req);
        logic [7:0] got;
        logic [7:0] r;
        time t0, t1;
        got = 8'h00; t0 = 0; t1 = 0;
        miso_i[s] = slv[7];
        miso_i[1-s] = ~slv[7];
        wr_reg(2'd2, tx);
        for (int i = 0; i < 8; i++) begin
            @(posedge sck_o[s]);
            if (i == 0) t0 = $time;
            if (i == 1) t1 = $time;
            got[7-i] = mosi_o[s];
            @(negedge sck_o[s]);
            if (i < 7) begin
                miso_i[s] = slv[6-i];
                miso_i[1-s] = ~slv[6-i];
            end
        end
        chk({req, " R2 mosi byte"}, {24'd0, got}, {24'd0, tx});
        chk({req, " R2 sck period"}, 32'(t1 - t0), 32'(2 * HALF * 8));
        chk({req, " R10 idle set enables"}, {28'd0, sck_oe[1-s], mosi_oe[1-s], miso_oe[1-s], ss_oe[1-s]}, 32'd0);
        idle(6);
        chk({req, " R2 sck idle low"}, {31'd0, sck_o[s]}, 32'd0);
        rd_reg(2'd1, r);
        chk({req, " R3 flag set"}, {24'd0, r}, 32'h80);
        rd_reg(2'd2, r);
        chk({req, " R2 rx byte"}, {24'd0, r}, {24'd0, slv});
        rd_reg(2'd1, r);
        chk({req, " R3 flag cleared"}, {24'd0, r}, 32'h00);
    endtask

    // Slave exchange on pad set 0; bench plays the remote master.
    task automatic slave_xfer(input logic [7:0] mst, input int nbits, output logic [7:0] seen, output int oe_bad);
        seen = 8'h00; oe_bad = 0;
        @(negedge clk);
        ss_i[0] = 1'b0;
        idle(8);
        for (int i = 0; i < nbits; i++) begin
            mosi_i[0] = mst[7-i];
            idle(8);
            seen[7-i] = miso_o[0];
            if (miso_oe[0] !== 1'b1) oe_bad++;
            sck_i[0] = 1'b1;
            idle(8);
            sck_i[0] = 1'b0;
        end
        idle(8);
        ss_i[0] = 1'b1;
        idle(6);
    endtask

    task automatic t_reset();
        logic [7:0] r;
        rd_reg(2'd0, r); chk("R1 ctrl", {24'd0, r}, 32'd0);
        rd_reg(2'd1, r); chk("R1 status", {24'd0, r}, 32'd0);
        rd_reg(2'd2, r); chk("R1 data", {24'd0, r}, 32'd0);
        chk("R1 enables", {24'd0, sck_oe, mosi_oe, miso_oe, ss_oe}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_master_set0();
        wr_reg(2'd0, C_EN | C_MST);
        idle(2);
        chk("R2 master enables", {30'd0, sck_oe[0], mosi_oe[0]}, 32'd3);
        master_xfer(0, 8'hA5, 8'h3C, "pat1");
        master_xfer(0, 8'h00, 8'hFF, "pat2");
        master_xfer(0, 8'h81, 8'h7E, "pat3");
    endtask

    task automatic t_irq();
        logic [7:0] r;
        wr_reg(2'd0, C_EN | C_MST | C_IE);
        glb_ie = 1'b0;
        miso_i[0] = 1'b1;
        wr_reg(2'd2, 8'h11);
        idle(16 * HALF + 20);
        chk("R3 irq masked by global", {31'd0, irq}, 32'd0);
        glb_ie = 1'b1;
        idle(1);
        chk("R3 irq asserted", {31'd0, irq}, 32'd1);
        rd_reg(2'd2, r);
        chk("R2 rx all ones", {24'd0, r}, 32'hFF);
        chk("R3 data access alone keeps flag", {31'd0, irq}, 32'd1);
        rd_reg(2'd1, r);
        chk("R3 flag still set", {24'd0, r}, 32'h80);
        rd_reg(2'd2, r);
        idle(1);
        chk("R3 irq cleared", {31'd0, irq}, 32'd0);
        glb_ie = 1'b0;
    endtask

    task automatic t_alt_set();
        logic [7:0] r;
        wr_reg(2'd0, C_EN | C_MST | C_ALT);
        ss_i[0] = 1'b0;
        master_xfer(1, 8'h5A, 8'hC6, "alt");
        rd_reg(2'd0, r);
        chk("R10 idle-set select ignored", {24'd0, r}, {24'd0, C_EN | C_MST | C_ALT});
        ss_i[0] = 1'b1;
    endtask

    task automatic t_sel_output();
        logic [7:0] r;
        wr_reg(2'd0, C_EN | C_MST | C_SOUT | C_SLVL);
        idle(2);
        chk("R7 select driven high", {30'd0, ss_oe[0], ss_o[0]}, 32'd3);
        ss_i[0] = 1'b0;
        idle(5);
        master_xfer(0, 8'h3C, 8'h81, "selout");
        rd_reg(2'd0, r);
        chk("R7 master kept", {31'd0, r[1]}, 32'd1);
        wr_reg(2'd0, C_EN | C_MST | C_SOUT);
        idle(1);
        chk("R7 select driven low", {30'd0, ss_oe[0], ss_o[0]}, 32'd2);
        ss_i[0] = 1'b1;
        idle(4);
    endtask

    task automatic t_fault();
        logic [7:0] r;
        wr_reg(2'd0, C_EN | C_MST);
        idle(4);
        wr_reg(2'd2, 8'hFF);
        @(posedge sck_o[0]);
        @(negedge clk);
        ss_i[0] = 1'b0;
        idle(6);
        chk("R8 drivers released", {29'd0, sck_oe[0], mosi_oe[0], sck_o[0]}, 32'd0);
        rd_reg(2'd0, r);
        chk("R8 master cleared", {24'd0, r}, {24'd0, C_EN});
        rd_reg(2'd1, r);
        chk("R8 flag set", {24'd0, r}, 32'h80);
        rd_reg(2'd2, r);
        ss_i[0] = 1'b1;
        idle(20);
        rd_reg(2'd0, r);
        chk("R9 master stays clear", {31'd0, r[1]}, 32'd0);
        wr_reg(2'd0, C_EN | C_IE);
        rd_reg(2'd0, r);
        chk("R9 other write keeps clear", {31'd0, r[1]}, 32'd0);
        wr_reg(2'd0, C_EN | C_MST);
        idle(1);
        rd_reg(2'd0, r);
        chk("R9 master restored", {31'd0, r[1]}, 32'd1);
        chk("R9 clock driver back", {31'd0, sck_oe[0]}, 32'd1);
    endtask

    task automatic t_slave();
        logic [7:0] r, seen;
        int bad;
        wr_reg(2'd0, C_EN);
        wr_reg(2'd2, 8'h5A);
        @(negedge clk); ss_i[0] = 1'b0;
        idle(6);
        chk("R4 miso off without enable", {31'd0, miso_oe[0]}, 32'd0);
        @(negedge clk); ss_i[0] = 1'b1;
        idle(4);
        wr_reg(2'd0, C_EN | C_MEN);
        slave_xfer(8'hC3, 8, seen, bad);
        chk("R4 miso byte", {24'd0, seen}, 32'h5A);
        chk("R4 miso enabled while selected", 32'(bad), 32'd0);
        chk("R4 miso released after select", {31'd0, miso_oe[0]}, 32'd0);
        rd_reg(2'd1, r);
        chk("R4 flag", {24'd0, r}, 32'h80);
        rd_reg(2'd2, r);
        chk("R4 rx byte", {24'd0, r}, 32'hC3);
    endtask

    task automatic t_unselected();
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            mosi_i[0] = i[0];
            idle(8); sck_i[0] = 1'b1;
            chk("R5 enables off", {28'd0, sck_oe[0], mosi_oe[0], miso_oe[0], ss_oe[0]}, 32'd0);
            idle(8); sck_i[0] = 1'b0;
        end
        idle(8);
        rd_reg(2'd1, r);
        chk("R5 no flag", {24'd0, r}, 32'h00);
        rd_reg(2'd2, r);
        chk("R5 data unchanged", {24'd0, r}, 32'hC3);
    endtask

    task automatic t_flush();
        logic [7:0] r, seen;
        int bad;
        wr_reg(2'd2, 8'h69);
        slave_xfer(8'hF0, 4, seen, bad);
        rd_reg(2'd1, r);
        chk("R6 partial sets no flag", {24'd0, r}, 32'h00);
        slave_xfer(8'h96, 8, seen, bad);
        chk("R6 tx reloaded", {24'd0, seen}, 32'h69);
        rd_reg(2'd1, r);
        chk("R6 flag after full byte", {24'd0, r}, 32'h80);
        rd_reg(2'd2, r);
        chk("R6 rx realigned", {24'd0, r}, 32'h96);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_master_set0();
        t_irq();
        t_alt_set();
        t_sel_output();
        t_fault();
        t_slave();
        t_unselected();
        t_flush();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule